// File: doc/BRIEF.md
# Programmable Sum-of-Products Array

This block is a configurable two-level logic engine. Twelve primary inputs and ten feedback lines are each offered to a programmable AND plane in both true and inverted form. Each of the 132 rows of a stored connection map forms one product term. A fixed OR plane then collects groups of terms into ten sums. The group size is largest in the middle outputs and smallest at the two ends. Each output also owns one separate product term that drives its three-state enable. Two shared terms are provided for a global asynchronous clear and a global clocked preset of downstream registers.

The connection map is loaded one row per clock through a write port and can be read back one row at a time through a read port. A protect bit hides the stored map: while it is set, every row reads back as if all connections were opened. The protect bit can be cleared only by a full wipe. A wipe clears the map one row per cycle. The same wipe also runs by itself after reset.

The control has two named states. WIPE clears row `wipe_row` on each clock and moves to READY after the last row, which also clears the protect bit. READY accepts writes. In READY, `erase_req` moves to WIPE at row 0 and `lock_set` sets the protect bit. Reset enters WIPE at row 0.

Top module: `pla_sop_array`

## Requirements
- R1: Columns are numbered with signal k at column 2k (true) and column 2k+1 (inverted). Signals 0..11 are `in_sig[0..11]` and signals 12..21 are `fb_sig[0..9]`. A map bit of 1 means the connection is opened. A product term is high exactly when every column whose map bit is 0 carries a 1.
- R2: A row whose 44 map bits are all 1 gives a high term for every input pattern.
- R3: A row with map bit 0 on both columns of the same signal gives a low term. The wiped state (all bits 0) therefore drives every sum, enable, clear and preset output low.
- R4: The row layout is as follows. Row 0 drives `clr_term` and row 131 drives `preset_term`. Output o has its enable row first, followed by its sum rows. The sum-row counts are 8, 10, 12, 14, 16, 16, 14, 12, 10 and 8 for o = 0..9, so the enable rows are 1, 10, 21, 34, 49, 66, 83, 98, 111 and 122.
- R5: `sum_out[o]` is the OR of its sum rows. Each sum follows input and feedback changes within the same cycle, with no clock.
- R6: A write with `cfg_addr` below 132 stores `cfg_wdata` at the next rising edge. A write to a higher address, or any write during WIPE, changes nothing.
- R7: When unprotected, `cfg_rdata` combinationally returns the row at `cfg_raddr`, and 0 for addresses of 132 or more.
- R8: `lock_set` in READY makes `cfg_rdata` all ones for every address from the next cycle on. The logic outputs are unaffected.
- R9: `erase_req` in READY makes `erase_busy` high from the next cycle for 132 cycles. All rows are cleared and the protect bit is cleared when the wipe ends. The protect bit stays set until then.
- R10: After reset is released, `erase_busy` stays high for 132 cycles, then the map is all zero and unprotected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_sig | input | 12 | Primary inputs |
| fb_sig | input | 10 | Feedback lines |
| cfg_we | input | 1 | Row write strobe |
| cfg_addr | input | 8 | Row write address |
| cfg_wdata | input | 44 | Row write data, 1 = connection opened |
| cfg_raddr | input | 8 | Row read address |
| cfg_rdata | output | 44 | Row read data |
| lock_set | input | 1 | Set the protect bit |
| erase_req | input | 1 | Start a full wipe |
| erase_busy | output | 1 | High while a wipe runs |
| sum_out | output | 10 | OR-plane sums |
| out_en_term | output | 10 | Per-output enable terms |
| clr_term | output | 1 | Shared asynchronous clear term |
| preset_term | output | 1 | Shared clocked preset term |

## Verification
The sums, enable terms, clear and preset terms, and read data are combinational. They are due in the same cycle that inputs or the read address change. The bench drives these inputs on the falling edge and samples 2 ns later. A row write, a protect request and a wipe request take effect at the next rising edge, so the bench sets them at one falling edge, removes them at the next, and checks afterwards. A wipe lasts 132 rising edges, counted one per cycle from the falling edge after its start, and the bench compares that count exactly.

// File: rtl/pla_pkg.sv
package pla_pkg;

    typedef enum logic {
        ST_WIPE  = 1'b0,
        ST_READY = 1'b1
    } cfg_state_e;

    // Sum-row count of output o: grows by step towards the middle outputs.
    function automatic int terms_of(int o, int n_out, int min_t, int step);
        int d;
        d = (o < n_out - 1 - o) ? o : n_out - 1 - o;
        return min_t + step * d;
    endfunction

    // Row index of the enable term of output o; its sum rows follow it.
    function automatic int en_row(int o, int n_out, int min_t, int step);
        int r;
        r = 1;
        for (int j = 0; j < o; j++) r += terms_of(j, n_out, min_t, step) + 1;
        return r;
    endfunction

    function automatic int total_rows(int n_out, int min_t, int step);
        return en_row(n_out, n_out, min_t, step) + 1;
    endfunction

endpackage

// File: rtl/pla_cfg_ctrl.sv
module pla_cfg_ctrl #(
    parameter int ROWS  = 132,
    parameter int N_COL = 44,
    parameter int AW    = 8
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        wr_en,
    input  logic [AW-1:0]               wr_addr,
    input  logic [N_COL-1:0]            wr_data,
    input  logic [AW-1:0]               rd_addr,
    output logic [N_COL-1:0]            rd_data,
    input  logic                        lock_set,
    input  logic                        erase_req,
    output logic                        busy,
    output logic [ROWS-1:0][N_COL-1:0]  fuse_map
);
    import pla_pkg::*;

    cfg_state_e state_q, state_d;
    logic [AW-1:0] wipe_q, wipe_d;
    logic secured_q, secured_d;
    logic [ROWS-1:0][N_COL-1:0] map_q;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q   <= ST_WIPE;
            wipe_q    <= '0;
            secured_q <= 1'b0;
        end else begin
            state_q   <= state_d;
            wipe_q    <= wipe_d;
            secured_q <= secured_d;
        end
    end

    // Next state
    always_comb begin
        state_d   = state_q;
        wipe_d    = wipe_q;
        secured_d = secured_q;
        unique case (state_q)
            ST_READY: begin
                if (lock_set) secured_d = 1'b1;
                if (erase_req) begin
                    state_d = ST_WIPE;
                    wipe_d  = '0;
                end
            end
            ST_WIPE: begin
                if (int'(wipe_q) == ROWS - 1) begin
                    state_d   = ST_READY;
                    secured_d = 1'b0;
                end else begin
                    wipe_d = wipe_q + 1'b1;
                end
            end
            default: state_d = ST_WIPE;
        endcase
    end

    // Outputs
    always_comb begin
        busy = (state_q == ST_WIPE);
        if (secured_q)
            rd_data = '1;
        else if (int'(rd_addr) < ROWS)
            rd_data = map_q[rd_addr];
        else
            rd_data = '0;
    end

    // Connection map storage
    always_ff @(posedge clk) begin
        if (state_q == ST_WIPE)
            map_q[wipe_q] <= '0;
        else if (wr_en && int'(wr_addr) < ROWS)
            map_q[wr_addr] <= wr_data;
    end

    assign fuse_map = map_q;

endmodule

// File: rtl/pla_and_plane.sv
module pla_and_plane #(
    parameter int N_SIG = 22,
    parameter int ROWS  = 132,
    localparam int N_COL = 2 * N_SIG
) (
    input  logic [N_SIG-1:0]            sig,
    input  logic [ROWS-1:0][N_COL-1:0]  fuse_map,
    output logic [ROWS-1:0]             term
);
    logic [N_COL-1:0] col;

    for (genvar k = 0; k < N_SIG; k++) begin : g_col
        assign col[2*k]   = sig[k];
        assign col[2*k+1] = ~sig[k];
    end

    // An opened connection (bit 1) forces its column to 1 in the AND.
    for (genvar r = 0; r < ROWS; r++) begin : g_row
        assign term[r] = &(col | fuse_map[r]);
    end

endmodule

// File: rtl/pla_or_plane.sv
module pla_or_plane #(
    parameter int N_OUT     = 10,
    parameter int MIN_TERMS = 8,
    parameter int TERM_STEP = 2,
    parameter int ROWS      = 132
) (
    input  logic [ROWS-1:0]  term,
    output logic [N_OUT-1:0] sum,
    output logic [N_OUT-1:0] out_en,
    output logic             clr,
    output logic             preset
);
    import pla_pkg::*;

    for (genvar o = 0; o < N_OUT; o++) begin : g_out
        localparam int EN  = en_row(o, N_OUT, MIN_TERMS, TERM_STEP);
        localparam int CNT = terms_of(o, N_OUT, MIN_TERMS, TERM_STEP);
        assign out_en[o] = term[EN];
        assign sum[o]    = |term[EN+1 +: CNT];
    end

    assign clr    = term[0];
    assign preset = term[ROWS-1];

endmodule

// File: rtl/pla_sop_array.sv
module pla_sop_array #(
    parameter int N_IN      = 12,
    parameter int N_FB      = 10,
    parameter int MIN_TERMS = 8,
    parameter int TERM_STEP = 2,
    localparam int N_OUT = N_FB,
    localparam int N_SIG = N_IN + N_FB,
    localparam int N_COL = 2 * N_SIG,
    localparam int ROWS  = pla_pkg::total_rows(N_OUT, MIN_TERMS, TERM_STEP),
    localparam int AW    = $clog2(ROWS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_IN-1:0]  in_sig,
    input  logic [N_FB-1:0]  fb_sig,
    input  logic             cfg_we,
    input  logic [AW-1:0]    cfg_addr,
    input  logic [N_COL-1:0] cfg_wdata,
    input  logic [AW-1:0]    cfg_raddr,
    output logic [N_COL-1:0] cfg_rdata,
    input  logic             lock_set,
    input  logic             erase_req,
    output logic             erase_busy,
    output logic [N_OUT-1:0] sum_out,
    output logic [N_OUT-1:0] out_en_term,
    output logic             clr_term,
    output logic             preset_term
);
    logic [ROWS-1:0][N_COL-1:0] fuse_map;
    logic [ROWS-1:0]            term;

    pla_cfg_ctrl #(.ROWS(ROWS), .N_COL(N_COL), .AW(AW)) u_cfg (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (cfg_we),
        .wr_addr   (cfg_addr),
        .wr_data   (cfg_wdata),
        .rd_addr   (cfg_raddr),
        .rd_data   (cfg_rdata),
        .lock_set  (lock_set),
        .erase_req (erase_req),
        .busy      (erase_busy),
        .fuse_map  (fuse_map)
    );

    pla_and_plane #(.N_SIG(N_SIG), .ROWS(ROWS)) u_and (
        .sig      ({fb_sig, in_sig}),
        .fuse_map (fuse_map),
        .term     (term)
    );

    pla_or_plane #(
        .N_OUT(N_OUT), .MIN_TERMS(MIN_TERMS), .TERM_STEP(TERM_STEP), .ROWS(ROWS)
    ) u_or (
        .term   (term),
        .sum    (sum_out),
        .out_en (out_en_term),
        .clr    (clr_term),
        .preset (preset_term)
    );

endmodule

// File: rtl/pla_sop_array_chk.sv
module pla_sop_array_chk #(
    parameter int ROWS  = 132,
    parameter int N_COL = 44,
    parameter int N_OUT = 10,
    parameter int AW    = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             cfg_we,
    input logic [AW-1:0]    cfg_addr,
    input logic [N_COL-1:0] cfg_wdata,
    input logic [AW-1:0]    cfg_raddr,
    input logic [N_COL-1:0] cfg_rdata,
    input logic             lock_set,
    input logic             erase_req,
    input logic             erase_busy,
    input logic [N_OUT-1:0] sum_out,
    input logic [N_OUT-1:0] out_en_term,
    input logic             clr_term,
    input logic             preset_term
);
    // R8: protect request in READY hides the map on the next cycle
    assert_lock_hides_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (lock_set && !erase_busy) |=> (cfg_rdata == '1));

    // R9: wipe request in READY starts the wipe on the next cycle
    assert_erase_starts_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (erase_req && !erase_busy) |=> erase_busy);

    // R3: at the end of a wipe every term is low and readback is unprotected zero
    assert_wiped_low_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(erase_busy) |-> (sum_out == '0 && out_en_term == '0 &&
                               !clr_term && !preset_term && cfg_rdata == '0));

    // R6: an accepted write reads back on the next cycle unless hidden
    assert_write_reads_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we && !erase_busy && int'(cfg_addr) < ROWS && cfg_raddr == cfg_addr)
        |=> (!$stable(cfg_raddr) || cfg_rdata == '1 || cfg_rdata == $past(cfg_wdata)));

endmodule

bind pla_sop_array pla_sop_array_chk #(
    .ROWS(ROWS), .N_COL(N_COL), .N_OUT(N_OUT), .AW(AW)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .cfg_we      (cfg_we),
    .cfg_addr    (cfg_addr),
    .cfg_wdata   (cfg_wdata),
    .cfg_raddr   (cfg_raddr),
    .cfg_rdata   (cfg_rdata),
    .lock_set    (lock_set),
    .erase_req   (erase_req),
    .erase_busy  (erase_busy),
    .sum_out     (sum_out),
    .out_en_term (out_en_term),
    .clr_term    (clr_term),
    .preset_term (preset_term)
);

// File: tb/tb_pla_sop_array.sv
module tb_pla_sop_array;
    localparam int NR = 132;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [11:0] in_sig = '0;
    logic [9:0]  fb_sig = '0;
    logic        cfg_we = 1'b0;
    logic [7:0]  cfg_addr = '0;
    logic [43:0] cfg_wdata = '0;
    logic [7:0]  cfg_raddr = '0;
    logic [43:0] cfg_rdata;
    logic        lock_set = 1'b0;
    logic        erase_req = 1'b0;
    logic        erase_busy;
    logic [9:0]  sum_out;
    logic [9:0]  out_en_term;
    logic        clr_term;
    logic        preset_term;

    int checks = 0;
    int fails  = 0;
    logic [43:0] mdl [NR];
    int tcount [10] = '{8, 10, 12, 14, 16, 16, 14, 12, 10, 8};

    always #10 clk = ~clk;

    pla_sop_array dut (
        .clk(clk), .rst_n(rst_n), .in_sig(in_sig), .fb_sig(fb_sig),
        .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
        .cfg_raddr(cfg_raddr), .cfg_rdata(cfg_rdata), .lock_set(lock_set),
        .erase_req(erase_req), .erase_busy(erase_busy), .sum_out(sum_out),
        .out_en_term(out_en_term), .clr_term(clr_term), .preset_term(preset_term)
    );

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic exp_term(int r);
        logic [43:0] c;
        for (int k = 0; k < 22; k++) begin
            logic s;
            s = (k < 12) ? in_sig[k] : fb_sig[k-12];
            c[2*k]   = s;
            c[2*k+1] = ~s;
        end
        return &(c | mdl[r]);
    endfunction

    task automatic check_logic(input string req);
        logic [9:0] es, ee;
        int r;
        r = 1;
        for (int o = 0; o < 10; o++) begin
            ee[o] = exp_term(r);
            es[o] = 1'b0;
            for (int t = 1; t <= tcount[o]; t++) es[o] |= exp_term(r + t);
            r += tcount[o] + 1;
        end
        chk(sum_out === es, req, 64'(sum_out), 64'(es));
        chk(out_en_term === ee, req, 64'(out_en_term), 64'(ee));
        chk({clr_term, preset_term} === {exp_term(0), exp_term(NR-1)}, req,
            64'({clr_term, preset_term}), 64'({exp_term(0), exp_term(NR-1)}));
    endtask

    task automatic drive_in(input logic [11:0] a, input logic [9:0] b);
        @(negedge clk);
        in_sig = a;
        fb_sig = b;
        #2;
    endtask

    task automatic write_row(input int addr, input logic [43:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = 8'(addr); cfg_wdata = d;
        @(negedge clk);
        if (addr < NR && !erase_busy_at_edge) mdl[addr] = d;
        cfg_we = 1'b0;
        #2;
    endtask

    logic erase_busy_at_edge;
    always @(posedge clk) erase_busy_at_edge <= erase_busy;

    task automatic read_chk(input int addr, input logic [43:0] exp, input string req);
        @(negedge clk);
        cfg_raddr = 8'(addr);
        #2;
        chk(cfg_rdata === exp, req, 64'(cfg_rdata), 64'(exp));
    endtask

    task automatic wait_idle(output int n);
        n = 0;
        while (erase_busy === 1'b1 && n < 1000) begin
            @(posedge clk);
            @(negedge clk);
            n++;
        end
        #2;
    endtask

    task automatic start_erase();
        @(negedge clk);
        erase_req = 1'b1;
        @(negedge clk);
        erase_req = 1'b0;
        #2;
        chk(erase_busy === 1'b1, "R9 busy after request", 64'(erase_busy), 64'd1);
        for (int i = 0; i < NR; i++) mdl[i] = '0;
    endtask

    function automatic logic [43:0] rnd_row();
        logic [43:0] a, b, c;
        a = 44'({$urandom(), $urandom()});
        b = 44'({$urandom(), $urandom()});
        c = 44'({$urandom(), $urandom()});
        return a | b | c;
    endfunction

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog (all requirements) actual=timeout expected=completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin : main
        int n;
        void'($urandom(32'd4242));
        for (int i = 0; i < NR; i++) mdl[i] = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #2;
        chk(erase_busy === 1'b1, "R10 busy after reset", 64'(erase_busy), 64'd1);
        wait_idle(n);
        chk(n == NR, "R10 wipe length", 64'(n), 64'(NR));

        // R3: wiped map drives all terms low
        drive_in(12'hFFF, 10'h3FF);
        check_logic("R3 wiped state");
        read_chk(5, '0, "R7 wiped row");
        read_chk(200, '0, "R7 out of range read");

        // R2: all-open preset row is high
        write_row(NR-1, '1);
        drive_in(12'h5A5, 10'h0F0);
        chk(preset_term === 1'b1, "R2 all open term", 64'(preset_term), 64'd1);

        // R1: clear row connected only to true in_sig[0]
        write_row(0, ~44'h1);
        drive_in(12'h001, 10'h0);
        chk(clr_term === 1'b1, "R1 single true column high", 64'(clr_term), 64'd1);
        drive_in(12'h000, 10'h0);
        chk(clr_term === 1'b0, "R1 single true column low", 64'(clr_term), 64'd0);
        // R1: inverted fb_sig[2] column (column 29)
        write_row(0, ~(44'h1 << 29));
        drive_in(12'h000, 10'h000);
        chk(clr_term === 1'b1, "R1 inverted feedback column", 64'(clr_term), 64'd1);

        // R3: both columns of fb_sig[3] (24+6, 24+7) on output 4 first sum row 50
        write_row(50, ~(44'h3 << 30));
        drive_in(12'h000, 10'h008);
        check_logic("R3 conflicting pair");
        chk(sum_out[4] === 1'b0, "R3 conflicting pair low", 64'(sum_out[4]), 64'd0);

        // R4: last sum row of output 9 (row 130) and enable of output 5 (row 66)
        write_row(130, '1);
        write_row(66, '1);
        #1;
        chk(sum_out === 10'h200, "R4 row 130 feeds output 9", 64'(sum_out), 64'h200);
        chk(out_en_term === 10'h020, "R4 row 66 enables output 5", 64'(out_en_term), 64'h020);

        // R6: write above range is ignored
        write_row(140, '1);
        check_logic("R6 out of range write");
        read_chk(130, '1, "R7 readback row 130");

        // R5/R6/R7: random map and patterns
        for (int it = 0; it < 30; it++) begin
            int a;
            logic [43:0] d;
            a = int'($urandom_range(0, 150));
            d = rnd_row();
            write_row(a, d);
            for (int p = 0; p < 8; p++) begin
                drive_in(12'($urandom()), 10'($urandom()));
                check_logic("R5 random sums");
            end
            if (a < NR) read_chk(a, d, "R6 write then read");
        end
        for (int r = 0; r < NR; r++) write_row(r, rnd_row());
        for (int p = 0; p < 100; p++) begin
            drive_in(12'($urandom()), 10'($urandom()));
            check_logic("R5 dense random");
        end

        // R8: protect
        @(negedge clk);
        lock_set = 1'b1;
        @(negedge clk);
        lock_set = 1'b0;
        read_chk(7, '1, "R8 protected read");
        read_chk(200, '1, "R8 protected read high address");
        drive_in(12'h3C3, 10'h155);
        check_logic("R8 logic unaffected");

        // R9: wipe clears map and protect bit
        start_erase();
        read_chk(7, '1, "R9 protect held during wipe");
        wait_idle(n);
        chk(n == NR - 1, "R9 wipe length", 64'(n + 1), 64'(NR));
        read_chk(7, '0, "R9 protect cleared");
        drive_in(12'hFFF, 10'h3FF);
        check_logic("R9 map cleared");

        // R6: write during wipe ignored
        start_erase();
        write_row(3, '1);
        wait_idle(n);
        read_chk(3, '0, "R6 write during wipe ignored");

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule